// File: doc/BRIEF.md
# Multi-Mode Instruction Fetch Memory Controller

This block sits between a processor's instruction fetch port and a 64 KB on-chip RAM organised as 2048 lines of 256-bit fetch packets (eight 32-bit words each). A 3-bit mode field, read from a control register input, decides at run time what the RAM does. It can act as plain memory inside a fixed 64 KB address window. It can act as a direct-mapped instruction cache that allocates on a miss. It can act as a frozen cache that serves hits but never allocates. It can also be bypassed, so that every fetch goes to external memory.

A fetch is accepted on any cycle where the request is high and the stall output is low. A window access or a cache hit answers in the next cycle, with no stall. A miss, a bypass fetch, or a fetch outside the window in plain-memory mode raises the stall instead. The block then reads the packet from a request/acknowledge external word port in ascending word order, with any latency per word. It delivers the packet in the cycle after the last acknowledge. The cache is flushed only when the mode changes from plain memory to cache-enabled.

Top module: `progmem_ctrl`

## Requirements
- R1: In mode 000 (plain memory), a fetch inside the active window answers one cycle after acceptance with no stall and no external request. It returns the packet held in RAM line `addr[15:5]`.
- R2: With `map_sel`=1 the window is 0x0000_0000–0x0000_FFFF. With `map_sel`=0 the window is 0x0140_0000–0x0140_FFFF. In plain-memory mode, an address outside the active window is fetched externally without touching the RAM.
- R3: After reset `fetch_stall`, `fetch_valid` and `ext_req` are low, every cache line is invalid, and the mode history counts as plain memory.
- R4: A fetch that must go external raises `fetch_stall` from the cycle after acceptance until the packet is delivered. The eight words are requested at line base + 4·k for k = 0..7, in that order.
- R5: The packet is presented with `fetch_valid` high and `fetch_stall` low in the cycle after the eighth acknowledge. Word k sits at bits [32k+31:32k].
- R6: In mode 010 (cache enabled), a fetch whose line is valid and whose tag (`addr[31:16]`) matches answers one cycle after acceptance with no stall and no external request.
- R7: In mode 011 (cache frozen), hits behave as in R6. A miss is fetched externally and delivered but not stored, so a repeat fetch of the same line misses again.
- R8: A change of the mode field from 000 to 010 invalidates every line. Changes from 011 or bypass into 010 keep the cache contents.
- R9: Mode 100, and the unused codes 001, 101, 110 and 111, are bypass. Every non-window fetch goes external, and the cache is neither read nor written.
- R10: In any mode other than 000, a fetch inside the window answers one cycle after acceptance with no stall and no external request, and its data is unspecified.
- R11: The mode field is bits [7:5] of `ctl_reg`. All other bits of `ctl_reg` have no effect.
- R12: `ext_req` stays high with a stable `ext_addr` until `ext_ack`. A fill takes exactly eight acknowledges, whatever the latency.
- R13: The cache is direct-mapped on `addr[15:5]`. A fill for a different tag at the same index evicts the previous line, so the earlier address misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_reg | input | 32 | Control register; bits [7:5] select the mode |
| map_sel | input | 1 | Window base select (1: low map, 0: high map) |
| fetch_req | input | 1 | Fetch request |
| fetch_addr | input | 32 | Byte address of the requested fetch packet |
| fetch_stall | output | 1 | Processor must hold; no new fetch is accepted |
| fetch_valid | output | 1 | Fetch packet on `fetch_data` is valid this cycle |
| fetch_data | output | 256 | Fetch packet, word k at bits [32k+31:32k] |
| ext_req | output | 1 | External word read request |
| ext_addr | output | 32 | External word byte address |
| ext_ack | input | 1 | External word returned this cycle |
| ext_rdata | input | 32 | External word data |

## Verification
The in-RTL properties check on every cycle that:
- a request is held steady until it is acknowledged, and fill addresses step up by one word;
- valid and stall are never high together, and the stall is released right after the last word;
- a flush leaves no valid line;
- no window address ever reaches the external port.

Only the bench's scenarios can show that data is right and that allocation follows the mode. That covers what a hit returns after a fill, the refetch of a frozen miss, eviction at a shared index, and whether the cache survives each kind of mode change. The bench checks these against a reference model of the lines and tags, under random acknowledge latency.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    PM_PLAIN    = 2'd0,
    PM_CACHE_ON = 2'd1,
    PM_FROZEN   = 2'd2,
    PM_BYPASS   = 2'd3
  } pm_mode_e;

  typedef enum logic [1:0] {
    FK_WINDOW   = 2'd0,
    FK_CACHED   = 2'd1,
    FK_EXTERNAL = 2'd2
  } fetch_kind_e;

  // 000 plain, 010 cache on, 011 frozen, all others bypass
  function automatic pm_mode_e decode_mode(input logic [2:0] field);
    case (field)
      3'b000:  return PM_PLAIN;
      3'b010:  return PM_CACHE_ON;
      3'b011:  return PM_FROZEN;
      default: return PM_BYPASS;
    endcase
  endfunction

endpackage

// File: rtl/pmc_store.sv
module pmc_store #(
  parameter int LINES     = 2048,
  parameter int WORD_W    = 32,
  parameter int PKT_WORDS = 8,
  localparam int IDX_W    = $clog2(LINES),
  localparam int WSEL_W   = $clog2(PKT_WORDS),
  localparam int PKT_W    = WORD_W * PKT_WORDS
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [PKT_W-1:0]  rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_sel,
  input  logic [WORD_W-1:0] wr_data
);

  logic [PKT_W-1:0] mem [LINES];
  logic [PKT_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx][wr_sel*WORD_W +: WORD_W] <= wr_data;
    if (rd_en) rd_q <= mem[rd_idx];
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/pmc_tagdir.sv
module pmc_tagdir #(
  parameter int LINES  = 2048,
  parameter int TAG_W  = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag
);

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tags [LINES];
  logic [TAG_W-1:0] tag_q;
  logic [IDX_W-1:0] rd_idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= '0;
      rd_idx_q <= '0;
    end else begin
      if (flush)  valid_q <= '0;
      if (set_en) valid_q[set_idx] <= 1'b1;
      if (rd_en)  rd_idx_q <= rd_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) tags[set_idx] <= set_tag;
    if (rd_en)  tag_q <= tags[rd_idx];
  end

  assign rd_tag   = tag_q;
  assign rd_valid = valid_q[rd_idx_q];

  // R8: a flush with no fill completing leaves no valid line
  a_r8_flush_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !set_en |=> valid_q == '0);

endmodule

// File: rtl/pmc_fill.sv
module pmc_fill #(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int PKT_WORDS = 8,
  localparam int WSEL_W   = $clog2(PKT_WORDS),
  localparam int BYTE_W   = $clog2(WORD_W / 8),
  localparam int LINE_LSB = WSEL_W + BYTE_W,
  localparam int PKT_W    = WORD_W * PKT_WORDS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [ADDR_W-LINE_LSB-1:0] line_base,
  output logic                       ext_req,
  output logic [ADDR_W-1:0]          ext_addr,
  input  logic                       ext_ack,
  input  logic [WORD_W-1:0]          ext_rdata,
  output logic                       wr_en,
  output logic [WSEL_W-1:0]          wr_sel,
  output logic [WORD_W-1:0]          wr_data,
  output logic                       fill_done,
  output logic                       busy,
  output logic [PKT_W-1:0]           packet
);

  logic                       busy_q;
  logic [WSEL_W-1:0]          cnt_q;
  logic [ADDR_W-LINE_LSB-1:0] base_q;
  logic [PKT_W-1:0]           pkt_q;
  logic                       last_word;
  logic                       word_in;

  assign last_word = cnt_q == WSEL_W'(PKT_WORDS - 1);
  assign word_in   = busy_q && ext_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      base_q <= line_base;
    end else if (word_in) begin
      cnt_q <= cnt_q + 1'b1;
      if (last_word) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       pkt_q <= '0;
    else if (word_in) pkt_q[cnt_q*WORD_W +: WORD_W] <= ext_rdata;
  end

  assign ext_req   = busy_q;
  assign ext_addr  = {base_q, cnt_q, {BYTE_W{1'b0}}};
  assign wr_en     = word_in;
  assign wr_sel    = cnt_q;
  assign wr_data   = ext_rdata;
  assign fill_done = word_in && last_word;
  assign busy      = busy_q;
  assign packet    = pkt_q;

  // R12: an unanswered request is held with the same address
  a_r12_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && !ext_ack |=> ext_req && $stable(ext_addr));

  // R4: words of one packet are requested in ascending order
  a_r4_ascending_words: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && ext_ack && !last_word |=> ext_req && ext_addr == $past(ext_addr) + ADDR_W'(WORD_W / 8));

endmodule

// File: rtl/progmem_ctrl.sv
module progmem_ctrl
  import pmc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int PKT_WORDS = 8,
  parameter int LINES     = 2048,
  parameter int CTL_W     = 32,
  parameter int MODE_LSB  = 5,
  parameter logic [31:0] MAP0_BASE = 32'h0140_0000,
  parameter logic [31:0] MAP1_BASE = 32'h0000_0000,
  localparam int PKT_W    = WORD_W * PKT_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTL_W-1:0]  ctl_reg,
  input  logic              map_sel,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_stall,
  output logic              fetch_valid,
  output logic [PKT_W-1:0]  fetch_data,
  output logic              ext_req,
  output logic [ADDR_W-1:0] ext_addr,
  input  logic              ext_ack,
  input  logic [WORD_W-1:0] ext_rdata
);

  localparam int OFF_W  = $clog2(PKT_W / 8);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WSEL_W = $clog2(PKT_WORDS);

  function automatic logic in_window(input logic [ADDR_W-1:0] a, input logic ms);
    logic [ADDR_W-1:0] base;
    base = ms ? ADDR_W'(MAP1_BASE) : ADDR_W'(MAP0_BASE);
    return a[ADDR_W-1:IDX_W+OFF_W] == base[ADDR_W-1:IDX_W+OFF_W];
  endfunction

  function automatic logic [IDX_W-1:0] line_idx(input logic [ADDR_W-1:0] a);
    return a[IDX_W+OFF_W-1:OFF_W];
  endfunction

  function automatic logic [TAG_W-1:0] line_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W+OFF_W];
  endfunction

  // mode tracking and flush event
  pm_mode_e mode_now, mode_q;
  logic     flush_evt;

  assign mode_now  = decode_mode(ctl_reg[MODE_LSB +: 3]);
  assign flush_evt = (mode_q == PM_PLAIN) && (mode_now == PM_CACHE_ON);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= PM_PLAIN;
    else        mode_q <= mode_now;
  end

  // accepted-fetch registers
  logic          accept, pend_q, done_q, alloc_q;
  fetch_kind_e   kind_now, kind_q;
  logic [ADDR_W-1:0] addr_q;

  always_comb begin
    if (in_window(fetch_addr, map_sel))                        kind_now = FK_WINDOW;
    else if (mode_now == PM_CACHE_ON || mode_now == PM_FROZEN) kind_now = FK_CACHED;
    else                                                       kind_now = FK_EXTERNAL;
  end

  assign accept = fetch_req && !fetch_stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      kind_q  <= FK_WINDOW;
      alloc_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      pend_q <= accept;
      if (accept) begin
        kind_q  <= kind_now;
        alloc_q <= (kind_now == FK_CACHED) && (mode_now == PM_CACHE_ON);
        addr_q  <= {fetch_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      end
    end
  end

  // lookup result
  logic [TAG_W-1:0]  rd_tag;
  logic              rd_valid, hit_now, miss_now;
  logic [PKT_W-1:0]  ram_rd, fill_pkt;
  logic              fill_wr, fill_done, fill_busy;
  logic [WSEL_W-1:0] fill_sel;
  logic [WORD_W-1:0] fill_word;

  assign hit_now  = rd_valid && (rd_tag == line_tag(addr_q));
  assign miss_now = pend_q && ((kind_q == FK_EXTERNAL) || (kind_q == FK_CACHED && !hit_now));

  always_ff @(posedge clk) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= fill_done;
  end

  assign fetch_stall = miss_now || fill_busy;
  assign fetch_valid = (pend_q && !miss_now) || done_q;
  assign fetch_data  = done_q ? fill_pkt : ram_rd;

  pmc_store #(.LINES(LINES), .WORD_W(WORD_W), .PKT_WORDS(PKT_WORDS)) u_store (
    .clk    (clk),
    .rd_en  (accept),
    .rd_idx (line_idx(fetch_addr)),
    .rd_data(ram_rd),
    .wr_en  (fill_wr && alloc_q),
    .wr_idx (line_idx(addr_q)),
    .wr_sel (fill_sel),
    .wr_data(fill_word)
  );

  pmc_tagdir #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush_evt),
    .rd_en   (accept),
    .rd_idx  (line_idx(fetch_addr)),
    .rd_tag  (rd_tag),
    .rd_valid(rd_valid),
    .set_en  (fill_done && alloc_q),
    .set_idx (line_idx(addr_q)),
    .set_tag (line_tag(addr_q))
  );

  pmc_fill #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PKT_WORDS(PKT_WORDS)) u_fill (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (miss_now),
    .line_base(addr_q[ADDR_W-1:OFF_W]),
    .ext_req  (ext_req),
    .ext_addr (ext_addr),
    .ext_ack  (ext_ack),
    .ext_rdata(ext_rdata),
    .wr_en    (fill_wr),
    .wr_sel   (fill_sel),
    .wr_data  (fill_word),
    .fill_done(fill_done),
    .busy     (fill_busy),
    .packet   (fill_pkt)
  );

  logic unused_bits;
  assign unused_bits = ^{ctl_reg, fetch_addr[OFF_W-1:0], addr_q[OFF_W-1:0]};

  // R5: data is never offered while the processor is held
  a_r5_valid_excludes_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_valid && fetch_stall));

  // R5: the cycle after the last word delivers and releases
  a_r5_release_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> fetch_valid && !fetch_stall);

  // R4: a miss keeps the stall up while the fill starts
  a_r4_stall_into_fill: assert property (@(posedge clk) disable iff (!rst_n)
    miss_now |=> fetch_stall && ext_req);

  // R10: window addresses never reach the external port
  a_r10_window_internal: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> !in_window(ext_addr, map_sel));

  // R6: a hit answers with no external activity
  a_r6_hit_no_external: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && kind_q == FK_CACHED && hit_now |=> !ext_req);

endmodule

// File: tb/sim_progmem_ctrl.sv
module sim_progmem_ctrl;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [31:0]  ctl_reg;
  logic         map_sel;
  logic         fetch_req;
  logic [31:0]  fetch_addr;
  logic         fetch_stall, fetch_valid;
  logic [255:0] fetch_data;
  logic         ext_req;
  logic [31:0]  ext_addr;
  logic         ext_ack;
  logic [31:0]  ext_rdata;

  always #2 clk = ~clk;

  progmem_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ctl_reg(ctl_reg), .map_sel(map_sel),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_stall(fetch_stall), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .ext_req(ext_req), .ext_addr(ext_addr), .ext_ack(ext_ack), .ext_rdata(ext_rdata)
  );

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;

  // reference model of the line store
  logic [255:0] m_ram [2048];
  bit           m_wr  [2048];
  bit           m_val [2048];
  logic [15:0]  m_tag [2048];
  int           m_mode;   // 0 plain, 1 on, 2 frozen, 3 bypass

  function automatic logic [31:0] ext_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5EED_C0DE;
  endfunction

  function automatic logic [255:0] ext_packet(input logic [31:0] a);
    logic [255:0] p;
    for (int k = 0; k < 8; k++) p[k*32 +: 32] = ext_word({a[31:5], 5'd0} + 32'(4 * k));
    return p;
  endfunction

  function automatic bit bench_in_win(input logic [31:0] a, input logic ms);
    return ms ? (a[31:16] == 16'h0000) : (a[31:16] == 16'h0140);
  endfunction

  function automatic int bench_mode(input logic [2:0] f);
    if (f == 3'b000) return 0;
    if (f == 3'b010) return 1;
    if (f == 3'b011) return 2;
    return 3;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // external memory responder with random latency
  logic [31:0] ack_log [16];
  int          log_n = 0;
  int          lat   = 0;

  always @(negedge clk) begin
    ext_ack = 1'b0;
    if (ext_req) begin
      if (lat == 0) begin
        ext_ack   = 1'b1;
        ext_rdata = ext_word(ext_addr);
        if (log_n < 16) ack_log[log_n] = ext_addr;
        log_n++;
        lat = int'($urandom % 4);
      end else begin
        lat--;
      end
    end
  end

  task automatic do_fetch(input logic [31:0] a, output logic [255:0] d,
                          output int stalls, output int nw, output bit stall_ok);
    int guard = 0;
    stalls = 0; stall_ok = 1; d = '0;
    @(negedge clk);
    log_n = 0;
    fetch_req  = 1'b1;
    fetch_addr = a;
    @(posedge clk);
    forever begin
      @(negedge clk);
      fetch_req  = 1'b0;
      fetch_addr = $urandom;
      if (fetch_valid) begin d = fetch_data; break; end
      stalls++;
      if (!fetch_stall) stall_ok = 0;
      guard++;
      if (guard > 500) begin chk(0, "R4", "fetch never completed", 0, 1); break; end
    end
    nw = log_n;
  endtask

  // R11: the field sits at bits 7:5; the other bits are random noise
  task automatic set_mode(input logic [2:0] f);
    int nm;
    @(negedge clk);
    ctl_reg = $urandom;
    ctl_reg[7:5] = f;
    nm = bench_mode(f);
    if (m_mode == 0 && nm == 1) for (int i = 0; i < 2048; i++) m_val[i] = 0;
    m_mode = nm;
    @(negedge clk);
  endtask

  task automatic set_map(input logic ms);
    @(negedge clk);
    map_sel = ms;
    @(negedge clk);
  endtask

  // fetch and compare against the model; returns data and external word count
  task automatic fetch_check(input logic [31:0] a, output logic [255:0] d, output int nw);
    int stalls;
    bit sok, in_w, hit;
    logic [10:0] idx;
    logic [15:0] tg;
    string rq;
    idx  = a[15:5];
    tg   = a[31:16];
    in_w = bench_in_win(a, map_sel);
    hit  = (m_mode == 1 || m_mode == 2) && m_val[idx] && m_tag[idx] == tg;
    do_fetch(a, d, stalls, nw, sok);
    if (in_w) begin
      rq = (m_mode == 0) ? "R1" : "R10";
      chk(nw == 0 && stalls == 0, rq, "window fetch external/stall", 256'(nw), 0);
      if (m_mode == 0 && m_wr[idx]) chk(d == m_ram[idx], "R1", "window data", d, m_ram[idx]);
    end else if (hit) begin
      chk(nw == 0 && stalls == 0, "R6", "hit external/stall", 256'(nw), 0);
      chk(d == m_ram[idx], "R6", "hit data", d, m_ram[idx]);
    end else begin
      rq = (m_mode == 2) ? "R7" : (m_mode == 3) ? "R9" : (m_mode == 0) ? "R2" : "R4";
      chk(nw == 8, "R12", "word count", 256'(nw), 8);
      chk(stalls > 0 && sok, rq, "stall during fill", 256'(stalls), 1);
      for (int k = 0; k < 8 && k < nw; k++)
        chk(ack_log[k] == {a[31:5], 5'd0} + 32'(4 * k), "R4", "word order",
            256'(ack_log[k]), 256'({a[31:5], 5'd0} + 32'(4 * k)));
      chk(d == ext_packet(a), "R5", "filled packet", d, ext_packet(a));
      if (m_mode == 1) begin
        m_val[idx] = 1; m_tag[idx] = tg; m_ram[idx] = ext_packet(a); m_wr[idx] = 1;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [255:0] d;
    int nw;
    logic [31:0] A, B, C, D;
    logic [2:0] mlist [8];
    void'($urandom(32'd20240611));
    A = 32'h0002_0040; B = 32'h0003_0040; C = 32'h0005_0080; D = 32'h0006_00C0;
    mlist = '{3'd0, 3'd2, 3'd3, 3'd4, 3'd1, 3'd5, 3'd6, 3'd7};
    for (int i = 0; i < 2048; i++) begin m_val[i] = 0; m_wr[i] = 0; m_tag[i] = '0; end
    m_mode = 0;
    rst_n = 1'b0; fetch_req = 1'b0; fetch_addr = '0; ctl_reg = '0; map_sel = 1'b1;
    ext_ack = 1'b0; ext_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: quiet outputs after reset
    chk(!fetch_stall && !fetch_valid && !ext_req, "R3", "reset outputs",
        {fetch_stall, fetch_valid, ext_req}, 0);

    set_mode(3'b010);                       // plain -> on: flush
    fetch_check(A, d, nw);
    chk(nw == 8, "R11", "enable via bits 7:5 then first fetch misses", 256'(nw), 8);
    chk(d == ext_packet(A), "R5", "first fill data", d, ext_packet(A));
    fetch_check(A, d, nw);
    chk(nw == 0, "R6", "repeat fetch hits", 256'(nw), 0);
    fetch_check(B, d, nw);
    fetch_check(A, d, nw);
    chk(nw == 8, "R13", "evicted line misses", 256'(nw), 8);

    set_mode(3'b000);
    fetch_check(32'h0000_0040, d, nw);
    chk(d == ext_packet(A), "R1", "plain window returns stored line", d, ext_packet(A));
    fetch_check(32'h0140_0040, d, nw);
    chk(nw == 8, "R2", "high map address outside low window", 256'(nw), 8);
    set_map(1'b0);
    fetch_check(32'h0140_0040, d, nw);
    chk(nw == 0 && d == ext_packet(A), "R2", "high window internal", d, ext_packet(A));
    set_map(1'b1);

    set_mode(3'b011);                       // plain -> frozen: no flush
    fetch_check(A, d, nw);
    chk(nw == 0, "R7", "frozen hit", 256'(nw), 0);
    fetch_check(C, d, nw);
    fetch_check(C, d, nw);
    chk(nw == 8, "R7", "frozen miss not stored", 256'(nw), 8);

    set_mode(3'b010);                       // frozen -> on: keep
    fetch_check(A, d, nw);
    chk(nw == 0, "R8", "frozen to enabled keeps lines", 256'(nw), 0);

    set_mode(3'b100);
    fetch_check(A, d, nw);
    chk(nw == 8, "R9", "bypass ignores cached line", 256'(nw), 8);
    set_mode(3'b111);
    fetch_check(D, d, nw);
    chk(nw == 8, "R9", "code 111 acts as bypass", 256'(nw), 8);
    set_mode(3'b010);                       // bypass -> on: keep
    fetch_check(A, d, nw);
    chk(nw == 0, "R9", "bypass left cache intact", 256'(nw), 0);
    fetch_check(D, d, nw);
    chk(nw == 8, "R9", "bypass did not allocate", 256'(nw), 8);
    fetch_check(32'h0000_0100, d, nw);
    chk(nw == 0, "R10", "window in cache mode stays internal", 256'(nw), 0);

    set_mode(3'b000);
    set_mode(3'b010);                       // plain -> on: flush
    fetch_check(A, d, nw);
    chk(nw == 8, "R8", "flush on plain to enabled", 256'(nw), 8);

    // constrained random phase
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      logic [15:0] tg;
      if ($urandom % 16 == 0) set_mode(mlist[$urandom % 8]);
      if ($urandom % 40 == 0) set_map(1'($urandom % 2));
      case ($urandom % 6)
        0: tg = 16'h0000;
        1: tg = 16'h0140;
        2: tg = 16'h0002;
        3: tg = 16'h0003;
        4: tg = 16'h0007;
        default: tg = 16'h1234;
      endcase
      a = {tg, 5'd0, 3'($urandom % 8), 3'($urandom), 5'($urandom)};
      fetch_check(a, d, nw);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule